// File: doc/BRIEF.md
# Hamming Encoder with Serial Output

This block takes a 25-bit data word and turns it into a 30-bit codeword that can correct any single-bit error. Five check bits are added, one at each codeword position that is a power of two. The codeword is then sent out one bit per clock on a single serial line.

A producer offers a word with `in_valid` and the block takes it with `in_ready`. A per-word input, `in_odd`, chooses whether each check-bit group XORs to zero or to one. The block encodes the word, loads the codeword into a shift register, and sends it lowest position first. `ser_strobe` is high for every cycle that carries a codeword bit. The mode and the data are fixed on the clock edge that accepts the word, so a frame in flight does not depend on later input values.

Top module: `hamming_ser_tx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `in_ready` is 1, `ser_strobe` is 0 and `ser_bit` is 0.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `ser_strobe` goes high in the cycle that follows that edge.
- R3: Each accepted word produces exactly 30 consecutive cycles with `ser_strobe` high. `in_ready` is 0 during all of them and returns to 1 in the cycle after the last one.
- R4: Codeword positions are numbered 1 to 30. Position k is driven on `ser_bit` in the k-th strobe cycle of the frame, so position 1 goes first and position 30 goes last.
- R5: Check bits occupy positions 1, 2, 4, 8 and 16. Data bit `in_data[i]` occupies the (i+1)-th remaining position in ascending order: bit 0 at position 3 and bit 24 at position 30.
- R6: The check bit at position 2^j covers every position whose index has bit j set. When `in_odd` is 0 at acceptance, the XOR over each such group is 0.
- R7: When `in_odd` is 1 at acceptance, the XOR over each such group is 1.
- R8: Changes to `in_data` or `in_odd` after the accepting edge do not alter the frame being sent.
- R9: `in_valid` raised while a frame is being sent is ignored. The frame is not restarted or altered, and no extra word is taken.
- R10: `ser_bit` is 0 in every cycle where `ser_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to `clk` |
| in_valid | input | 1 | A data word is offered |
| in_data | input | 25 | Data word to encode |
| in_odd | input | 1 | Parity mode: 0 = even groups, 1 = odd groups |
| in_ready | output | 1 | The block can accept a word this cycle |
| ser_bit | output | 1 | Serial codeword bit |
| ser_strobe | output | 1 | High while `ser_bit` carries a codeword bit |

## Verification
Take the rising edge that accepts a word as edge zero. Position k of the codeword appears on `ser_bit` in the cycle that follows edge k-1. `ser_strobe` stays high from the cycle after edge zero through the cycle after edge 29. `in_ready` returns to 1 in the cycle after edge 30.

The bench reference model advances on the same rising edges as the design, using a queue of expected bits filled when a word is accepted. The outputs are compared against that model at every falling edge, so each sample falls midway through the cycle in which a result is due. Separately, each received frame of 30 bits is decoded on its own, group by group, to confirm the parity relations and the data placement.

// File: rtl/hser_pkg.sv
package hser_pkg;

  // Number of check bits needed for a single-error-correcting code over n data bits.
  function automatic int chk_bits(input int n);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) begin
      if ((1 << r) < n + r + 1) r++;
    end
    return r;
  endfunction

  // True when p is a power of two (p >= 1).
  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

endpackage

// File: rtl/hser_encoder.sv
module hser_encoder #(
  parameter int DATA_W = 25
) (
  input  logic [DATA_W-1:0]                                 data_i,
  input  logic                                              odd_i,
  output logic [DATA_W+hser_pkg::chk_bits(DATA_W)-1:0]      code_o
);
  localparam int CHK_W  = hser_pkg::chk_bits(DATA_W);
  localparam int CODE_W = DATA_W + CHK_W;

  logic [CODE_W-1:0] spread;   // data placed, zeros at check positions
  logic [CHK_W-1:0]  chk;

  // Data placement: non-power-of-two position p carries data bit p-1-clog2(p).
  for (genvar p = 1; p <= CODE_W; p++) begin : g_place
    if (hser_pkg::is_pow2(p)) begin : g_chk_slot
      assign spread[p-1] = 1'b0;
      assign code_o[p-1] = chk[$clog2(p)];
    end else begin : g_data_slot
      assign spread[p-1] = data_i[p-1-$clog2(p)];
      assign code_o[p-1] = spread[p-1];
    end
  end

  // Each check bit closes the parity of the positions whose index has its bit set.
  always_comb begin
    chk = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      for (int j = 0; j < CHK_W; j++) begin
        if (((p >> j) & 1) == 1) chk[j] = chk[j] ^ spread[p-1];
      end
    end
    chk = chk ^ {CHK_W{odd_i}};
  end

endmodule

// File: rtl/hser_piso.sv
module hser_piso #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o,
  output logic         active_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sreg_q, sreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             en;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (act_q) begin
      sreg_d = {1'b0, sreg_q[W-1:1]};
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (load_i) begin
      sreg_d = word_i;
      act_d  = 1'b1;
      cnt_d  = '0;
    end
  end

  assign en = act_q | load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (en) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign bit_o    = sreg_q[0];
  assign active_o = act_q;

endmodule

// File: rtl/hamming_ser_tx.sv
module hamming_ser_tx #(
  parameter int DATA_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_odd,
  output logic              in_ready,
  output logic              ser_bit,
  output logic              ser_strobe
);
  localparam int CHK_W  = hser_pkg::chk_bits(DATA_W);
  localparam int CODE_W = DATA_W + CHK_W;

  logic [CODE_W-1:0] codeword;
  logic              accept;
  logic              busy;

  hser_encoder #(.DATA_W(DATA_W)) u_enc (
    .data_i (in_data),
    .odd_i  (in_odd),
    .code_o (codeword)
  );

  assign accept = in_valid & in_ready;

  hser_piso #(.W(CODE_W)) u_piso (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .word_i   (codeword),
    .bit_o    (ser_bit),
    .active_o (busy)
  );

  assign in_ready   = ~busy;
  assign ser_strobe = busy;

endmodule

// File: rtl/hser_checker.sv
module hser_checker #(
  parameter int DATA_W = 25
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ser_bit,
  input logic ser_strobe
);
  localparam int CODE_W = DATA_W + hser_pkg::chk_bits(DATA_W);
  localparam int RUN_W  = $clog2(CODE_W + 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (ser_strobe) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  // R2: an accepted word starts the strobe in the next cycle
  a_r2_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ser_strobe);

  // R3: no word is taken while bits are going out
  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe |-> !in_ready);

  // R3: a strobe run never exceeds one codeword
  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe |-> (run_q < RUN_W'(CODE_W)));

  // R3: every strobe run is exactly one codeword long
  a_r3_run_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_strobe) |-> (run_q == RUN_W'(CODE_W)));

  // R3: ready comes back as soon as the strobe ends
  a_r3_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_strobe) |-> in_ready);

  // R10: the line is quiet outside a frame
  a_r10_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_strobe |-> !ser_bit);

endmodule

bind hamming_ser_tx hser_checker #(.DATA_W(DATA_W)) u_hser_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .ser_bit    (ser_bit),
  .ser_strobe (ser_strobe)
);

// File: tb/tb_hamming_ser_tx.sv
module tb_hamming_ser_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 25;
  localparam int CW = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_odd;
  logic          in_ready, ser_bit, ser_strobe;

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";

  bit            mq[$];
  bit            acc_flag;
  logic [DW-1:0] last_data;
  bit            last_odd;
  bit            rx[1:CW];
  int            rxn;

  hamming_ser_tx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_odd(in_odd), .in_ready(in_ready), .ser_bit(ser_bit), .ser_strobe(ser_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference codeword built straight from R5/R6/R7; index = position.
  function automatic logic [CW:0] make_code(input logic [DW-1:0] d, input bit odd);
    logic [CW:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p <= CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[di];
        di++;
      end
    end
    for (int j = 0; j < 5; j++) begin
      bit par;
      par = 0;
      for (int p = 1; p <= CW; p++) if ((p & (1 << j)) != 0) par ^= c[p];
      c[1 << j] = par ^ odd;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: advances on each rising edge like the design.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
    end else if (mq.size() != 0) begin
      void'(mq.pop_front());
    end else if (in_valid) begin
      logic [CW:0] c;
      c = make_code(in_data, in_odd);
      for (int p = 1; p <= CW; p++) mq.push_back(c[p]);
      last_data = in_data;
      last_odd  = in_odd;
      acc_flag  = 1'b1;
    end
  end

  // Per-cycle comparison and frame decoding at falling edges.
  always @(negedge clk) begin
    if (!rst_n) begin
      rxn = 0;
    end else begin
      bit eb;
      eb = (mq.size() != 0) ? mq[0] : 1'b0;
      check(ser_strobe == (mq.size() != 0), "R3", "strobe", ser_strobe, mq.size() != 0);
      check(in_ready == (mq.size() == 0), "R3", "ready", in_ready, mq.size() == 0);
      check(ser_bit == eb, (mq.size() == 0) ? "R10" : cur_req, "bit", ser_bit, eb);
      if (ser_strobe) begin
        rxn++;
        if (rxn <= CW) rx[rxn] = ser_bit;
        if (rxn == CW) begin
          logic [DW-1:0] got;
          int di;
          di = 0;
          got = '0;
          for (int p = 1; p <= CW; p++) if ((p & (p - 1)) != 0) begin got[di] = rx[p]; di++; end
          check(got == last_data, "R5", "decoded data", got, last_data);
          for (int j = 0; j < 5; j++) begin
            bit par;
            par = 0;
            for (int p = 1; p <= CW; p++) if ((p & (1 << j)) != 0) par ^= rx[p];
            check(par == last_odd, last_odd ? "R7" : "R6", "group parity", par, last_odd);
          end
          rxn = 0;
        end
      end
    end
  end

  task automatic send(input logic [DW-1:0] d, input bit odd, input string tag);
    cur_req = tag;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_odd   = odd;
    acc_flag = 1'b0;
    do @(negedge clk); while (!acc_flag);
    in_valid = 1'b0;
    // R2: first strobe cycle follows the accepting edge, carrying position 1 (R4)
    check(ser_strobe == 1'b1, "R2", "strobe after accept", ser_strobe, 1);
    check(ser_bit == make_code(d, odd)[1], "R4", "first bit", ser_bit, make_code(d, odd)[1]);
  endtask

  task automatic wait_idle();
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_odd = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1 && ser_strobe == 0 && ser_bit == 0, "R1", "in reset", {in_ready, ser_strobe, ser_bit}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1 && ser_strobe == 0 && ser_bit == 0, "R1", "after reset", {in_ready, ser_strobe, ser_bit}, 3'b100);

    send('0, 1'b0, "R6"); wait_idle();
    send('0, 1'b1, "R7"); wait_idle();
    send('1, 1'b0, "R6"); wait_idle();
    send('1, 1'b1, "R7"); wait_idle();
    send(25'h0AAAAAA, 1'b0, "R5"); wait_idle();
    send(25'h1555555, 1'b1, "R5"); wait_idle();
    send(25'h0000001, 1'b0, "R4"); wait_idle();
    send(25'h1000000, 1'b1, "R4"); wait_idle();
    for (int i = 0; i < 8; i++) begin
      send(DW'($urandom), 1'($urandom), "R4");
      wait_idle();
    end

    // R8 and R9: inputs move and valid is held while a frame is going out
    send(25'h0123456, 1'b0, "R8");
    in_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      in_data = DW'($urandom);
      in_odd  = ~in_odd;
      check(in_ready == 1'b0, "R9", "busy ignores valid", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_idle();

    // R2/R3: valid held across frames gives back-to-back words with one idle cycle
    cur_req  = "R2";
    in_data  = 25'h1F0F0F0;
    in_odd   = 1'b1;
    in_valid = 1'b1;
    repeat (70) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R1: reset in the middle of a frame
    send(25'h0BEEF12, 1'b0, "R1");
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(in_ready == 1 && ser_strobe == 0 && ser_bit == 0, "R1", "mid-frame reset", {in_ready, ser_strobe, ser_bit}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1 && ser_strobe == 0 && ser_bit == 0, "R1", "after mid reset", {in_ready, ser_strobe, ser_bit}, 3'b100);
    send(25'h1234567, 1'b1, "R7"); wait_idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule